// File: doc/BRIEF.md
# Load-Use Stall and Branch Penalty Meter

This block watches the issue stream of a 16-register in-order core and works out what each instruction costs in extra cycles. For every issued instruction it takes the functional-unit class, up to two source register indexes with their valid flags, a destination index and a branch-taken flag. A load marks its destination as pending. At the instruction boundary the pending set becomes the active set, and the following instruction is checked against the active set.

Execute, compare and multiply-accumulate instructions test both valid sources against the active set. A control transfer tests only its first source. Each hit costs a fixed load penalty. A taken control transfer costs a fixed branch penalty. The per-instruction charge is reported at once on a combinational output. Four wrapping counters keep the running totals of load-stall cycles, branch-stall cycles, taken transfers and untaken transfers.

The block only measures. It does not hold the pipeline, forward values or decode instructions.

Top module: `pipe_hazard_meter`

## Requirements
- R1: A load (unitClass 4) marks its destination register, and only the next issued instruction sees that mark. Cycles with issueValid low neither consume nor change the mark.
- R2: For execute (0), compare (1) and multiply-accumulate (2), each valid source that hits the active mark adds 2 cycles. Two hits, including the same register named twice, add 4.
- R3: A source whose valid flag is low is never checked and adds nothing.
- R4: A control transfer (unitClass 3) checks srcA alone for a load hit, adding 2 on a hit. srcB is ignored.
- R5: A taken control transfer adds 2 cycles, adds 2 to branchStallCount and increments takenCount. An untaken one adds nothing and increments untakenCount.
- R6: Load (4) and store (5) instructions never check their sources, even when those sources hit the active mark.
- R7: Any issued instruction that is not a load leaves the active mark empty for the instruction after it.
- R8: stallCycles is the combined charge of the instruction currently presented with issueValid high, and 0 when issueValid is low. loadStallCount accumulates the load part of each charge.
- R9: A synchronous reset clears all counters and the pending mark. The counters are 32 bits wide and wrap.
- R10: Unused class codes 6 and 7 check nothing, count nothing, cost 0 and clear the mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An instruction issues this cycle |
| unitClass | input | 3 | Functional-unit class, codes 0 to 5 |
| srcA | input | 4 | First source register index |
| srcAValid | input | 1 | First source is present |
| srcB | input | 4 | Second source register index |
| srcBValid | input | 1 | Second source is present |
| dstReg | input | 4 | Destination register index |
| branchTaken | input | 1 | The control transfer is taken |
| stallCycles | output | 3 | Extra cycles charged to this instruction |
| loadStallCount | output | 32 | Running total of load-use stall cycles |
| branchStallCount | output | 32 | Running total of branch stall cycles |
| takenCount | output | 32 | Taken control transfers |
| untakenCount | output | 32 | Untaken control transfers |

## Verification
The hazard check runs with a load followed by a consumer that uses the loaded register:
- through one source, which shows the per-source charge;
- through both sources, which shows that the charges add up;
- with the valid flag dropped, which shows that absent sources are skipped.

Further sequences separate the classes by behaviour:
- Loads and stores that read a marked register, which shows that these classes skip the check.
- Control transfers with the hit in srcB only, which shows that only srcA is checked.
- Unused class codes.

An intervening non-load instruction and a run of idle cycles show that the mark lasts exactly one issued instruction and is not lost while no instruction issues. Counter totals and a mid-run reset close the sequence.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    UNIT_EXEC  = 3'd0,
    UNIT_CMP   = 3'd1,
    UNIT_MAC   = 3'd2,
    UNIT_CTI   = 3'd3,
    UNIT_LOAD  = 3'd4,
    UNIT_STORE = 3'd5
  } unit_e;

  typedef struct packed {
    logic advance;
    logic chkA;
    logic chkB;
    logic setLoad;
    logic brTaken;
    logic brUntaken;
  } hz_strobe_t;
endpackage

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issueValid,
  input  logic [2:0] unitClass,
  input  logic       srcAValid,
  input  logic       srcBValid,
  input  logic       branchTaken,
  output hz_strobe_t strb
);
  logic isAlu, isCti, isLoad;

  always_comb begin
    isAlu  = (unitClass == UNIT_EXEC) || (unitClass == UNIT_CMP) || (unitClass == UNIT_MAC);
    isCti  = (unitClass == UNIT_CTI);
    isLoad = (unitClass == UNIT_LOAD);
    strb.advance   = issueValid;
    strb.chkA      = issueValid && (isAlu || isCti) && srcAValid;
    strb.chkB      = issueValid && isAlu && srcBValid;
    strb.setLoad   = issueValid && isLoad;
    strb.brTaken   = issueValid && isCti && branchTaken;
    strb.brUntaken = issueValid && isCti && !branchTaken;
  end

  // R5: at most one of load/taken/untaken per instruction
  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.setLoad, strb.brTaken, strb.brUntaken}));
  // R6: loads never request a source check
  assert_load_no_check_R6: assert property (@(posedge clk) disable iff (rst)
    strb.setLoad |-> !(strb.chkA || strb.chkB));
  // R4: control transfers never check the second source
  assert_cti_no_srcb_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.brTaken || strb.brUntaken) |-> !strb.chkB);
endmodule

// File: rtl/hz_datapath.sv
module hz_datapath
  import hz_pkg::*;
#(
  parameter int REG_COUNT  = 16,
  parameter int IDX_W      = $clog2(REG_COUNT),
  parameter int CNT_W      = 32,
  parameter int LOAD_PEN   = 2,
  parameter int BRANCH_PEN = 2,
  parameter int STALL_W    = $clog2(2*LOAD_PEN + BRANCH_PEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  hz_strobe_t         strb,
  input  logic [IDX_W-1:0]   srcA,
  input  logic [IDX_W-1:0]   srcB,
  input  logic [IDX_W-1:0]   dstReg,
  output logic [STALL_W-1:0] stallCycles,
  output logic [CNT_W-1:0]   loadStallCount,
  output logic [CNT_W-1:0]   branchStallCount,
  output logic [CNT_W-1:0]   takenCount,
  output logic [CNT_W-1:0]   untakenCount
);
  logic [REG_COUNT-1:0] pendingMask;
  logic [REG_COUNT-1:0] activeMask;
  logic                 hitA, hitB;
  logic [STALL_W-1:0]   loadPart, branchPart;

  // pending set built by the current instruction
  always_comb begin
    pendingMask = '0;
    if (strb.setLoad) pendingMask[dstReg] = 1'b1;
  end

  always_comb begin
    hitA       = strb.chkA && activeMask[srcA];
    hitB       = strb.chkB && activeMask[srcB];
    loadPart   = STALL_W'((int'(hitA) + int'(hitB)) * LOAD_PEN);
    branchPart = strb.brTaken ? STALL_W'(BRANCH_PEN) : '0;
    stallCycles = loadPart + branchPart;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeMask       <= '0;
      loadStallCount   <= '0;
      branchStallCount <= '0;
      takenCount       <= '0;
      untakenCount     <= '0;
    end else if (strb.advance) begin
      activeMask     <= pendingMask;
      loadStallCount <= loadStallCount + CNT_W'(loadPart);
      if (strb.brTaken) begin
        branchStallCount <= branchStallCount + CNT_W'(BRANCH_PEN);
        takenCount       <= takenCount + 1'b1;
      end
      if (strb.brUntaken) untakenCount <= untakenCount + 1'b1;
    end
  end

  // R1: at most one register marked at a time
  assert_mask_single_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(activeMask));
  // R1: idle cycles leave the mark untouched
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |=> $stable(activeMask));
  // R5: taken transfer bumps takenCount by one
  assert_taken_step_R5: assert property (@(posedge clk) disable iff (rst)
    strb.brTaken |=> takenCount == $past(takenCount) + 1'b1);
  // R5: untaken transfer bumps untakenCount by one
  assert_untaken_step_R5: assert property (@(posedge clk) disable iff (rst)
    strb.brUntaken |=> untakenCount == $past(untakenCount) + 1'b1);
  // R8: nothing charged while no instruction issues
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !strb.advance |-> stallCycles == '0);
endmodule

// File: rtl/pipe_hazard_meter.sv
module pipe_hazard_meter
  import hz_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        issueValid,
  input  logic [2:0]  unitClass,
  input  logic [3:0]  srcA,
  input  logic        srcAValid,
  input  logic [3:0]  srcB,
  input  logic        srcBValid,
  input  logic [3:0]  dstReg,
  input  logic        branchTaken,
  output logic [2:0]  stallCycles,
  output logic [31:0] loadStallCount,
  output logic [31:0] branchStallCount,
  output logic [31:0] takenCount,
  output logic [31:0] untakenCount
);
  hz_strobe_t strb;

  hz_ctrl u_ctrl (
    .clk(clk), .rst(rst), .issueValid(issueValid), .unitClass(unitClass),
    .srcAValid(srcAValid), .srcBValid(srcBValid), .branchTaken(branchTaken),
    .strb(strb)
  );

  hz_datapath #(
    .REG_COUNT(16), .CNT_W(32), .LOAD_PEN(2), .BRANCH_PEN(2)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .srcA(srcA), .srcB(srcB), .dstReg(dstReg),
    .stallCycles(stallCycles), .loadStallCount(loadStallCount),
    .branchStallCount(branchStallCount), .takenCount(takenCount),
    .untakenCount(untakenCount)
  );
endmodule

// File: tb/pipe_hazard_meter_bench.sv
module pipe_hazard_meter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issueValid = 1'b0;
  logic [2:0]  unitClass = '0;
  logic [3:0]  srcA = '0, srcB = '0, dstReg = '0;
  logic        srcAValid = 1'b0, srcBValid = 1'b0, branchTaken = 1'b0;
  logic [2:0]  stallCycles;
  logic [31:0] loadStallCount, branchStallCount, takenCount, untakenCount;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipe_hazard_meter u_pipe_hazard_meter (
    .clk(clk), .rst(rst), .issueValid(issueValid), .unitClass(unitClass),
    .srcA(srcA), .srcAValid(srcAValid), .srcB(srcB), .srcBValid(srcBValid),
    .dstReg(dstReg), .branchTaken(branchTaken), .stallCycles(stallCycles),
    .loadStallCount(loadStallCount), .branchStallCount(branchStallCount),
    .takenCount(takenCount), .untakenCount(untakenCount)
  );

  typedef struct packed {
    logic [2:0] cls;
    logic [3:0] sa;
    logic       saV;
    logic [3:0] sb;
    logic       sbV;
    logic [3:0] dst;
    logic       tk;
    logic [2:0] expStall;
    logic [2:0] expLoad;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd5,  1'b0, 3'd0, 3'd0}, // load r5
    '{3'd0, 4'd5, 1'b1, 4'd2, 1'b1, 4'd0,  1'b0, 3'd2, 3'd2}, // R2 exec one hit
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd7,  1'b0, 3'd0, 3'd0}, // load r7
    '{3'd4, 4'd7, 1'b1, 4'd7, 1'b1, 4'd3,  1'b0, 3'd0, 3'd0}, // R6 load reads r7
    '{3'd5, 4'd3, 1'b1, 4'd3, 1'b1, 4'd0,  1'b0, 3'd0, 3'd0}, // R6 store reads r3
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9,  1'b0, 3'd0, 3'd0}, // load r9
    '{3'd2, 4'd9, 1'b1, 4'd9, 1'b1, 4'd0,  1'b0, 3'd4, 3'd4}, // R2 mac two hits
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd9,  1'b0, 3'd0, 3'd0}, // load r9
    '{3'd1, 4'd9, 1'b0, 4'd9, 1'b1, 4'd0,  1'b0, 3'd2, 3'd2}, // R3 cmp A absent
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd4,  1'b0, 3'd0, 3'd0}, // load r4
    '{3'd0, 4'd4, 1'b0, 4'd4, 1'b0, 4'd0,  1'b0, 3'd0, 3'd0}, // R3 both absent
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd1,  1'b0, 3'd0, 3'd0}, // load r1
    '{3'd3, 4'd1, 1'b1, 4'd0, 1'b0, 4'd0,  1'b1, 3'd4, 3'd2}, // R4 R5 cti hit taken
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd2,  1'b0, 3'd0, 3'd0}, // load r2
    '{3'd3, 4'd0, 1'b1, 4'd2, 1'b1, 4'd0,  1'b0, 3'd0, 3'd0}, // R4 srcB ignored, untaken
    '{3'd3, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0,  1'b1, 3'd2, 3'd0}, // R5 taken no hit
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd6,  1'b0, 3'd0, 3'd0}, // load r6
    '{3'd0, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 3'd0, 3'd0}, // exec no hit
    '{3'd0, 4'd6, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 3'd0, 3'd0}, // R7 mark gone
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd8,  1'b0, 3'd0, 3'd0}, // load r8
    '{3'd6, 4'd8, 1'b1, 4'd8, 1'b1, 4'd0,  1'b1, 3'd0, 3'd0}, // R10 unused code
    '{3'd0, 4'd8, 1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 3'd0, 3'd0}, // R10 mark cleared
    '{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd11, 1'b0, 3'd0, 3'd0}  // load r11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    issueValid = 1'b1; unitClass = v.cls; srcA = v.sa; srcAValid = v.saV;
    srcB = v.sb; srcBValid = v.sbV; dstReg = v.dst; branchTaken = v.tk;
  endtask

  task automatic idle();
    issueValid = 1'b0; srcAValid = 1'b0; srcBValid = 1'b0; branchTaken = 1'b0;
  endtask

  initial begin
    #2000000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] eLoad, eBr, eTk, eUn;
    eLoad = 0; eBr = 0; eTk = 0; eUn = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R9 reset loadStallCount", loadStallCount, 0);
    chk("R9 reset takenCount", takenCount, 0);
    chk("R8 idle stall", {29'd0, stallCycles}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      chk($sformatf("R2 vector %0d stall", i), {29'd0, stallCycles}, {29'd0, VECS[i].expStall});
      eLoad += VECS[i].expLoad;
      if (VECS[i].cls == 3'd3) begin
        if (VECS[i].tk) begin eTk++; eBr += 2; end
        else eUn++;
      end
    end

    // R1: idle cycles after the load of r11 keep the mark
    @(negedge clk); idle(); #1;
    chk("R8 no issue gives zero", {29'd0, stallCycles}, 0);
    repeat (3) @(negedge clk);
    drive('{3'd0, 4'd11, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0, 3'd0}); #1;
    chk("R1 mark survives idle", {29'd0, stallCycles}, 2);
    eLoad += 2;
    @(negedge clk); idle(); #1;

    chk("R8 loadStallCount", loadStallCount, eLoad);
    chk("R5 branchStallCount", branchStallCount, eBr);
    chk("R5 takenCount", takenCount, eTk);
    chk("R5 untakenCount", untakenCount, eUn);

    // R9: reset clears counters and a pending mark
    drive('{3'd4, 4'd0, 1'b0, 4'd0, 1'b0, 4'd5, 1'b0, 3'd0, 3'd0});
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk("R9 cleared loadStallCount", loadStallCount, 0);
    chk("R9 cleared branchStallCount", branchStallCount, 0);
    chk("R9 cleared untakenCount", untakenCount, 0);
    drive('{3'd0, 4'd5, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 3'd0, 3'd0}); #1;
    chk("R9 mark cleared by reset", {29'd0, stallCycles}, 0);
    @(negedge clk); idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule